// File: doc/BRIEF.md
# Per-Channel Digital Volume with Soft Mute

This block scales a set of parallel 32-bit signed audio channels by a gain picked from an 8-bit level code. The codes are 0.5 dB apart. Each channel has its own code input. The block never applies a new code at once. Each channel keeps a present level that walks one code at a time toward its target. The walk runs at a pace set by a two-bit rate select, counted in accepted samples.

A global soft-mute request moves every channel's target to code 0, which means silence. The levels then glide down from wherever they are. When the request drops, the levels glide back up to the codes in force. The same scaling path serves PCM words and sign-extended one-bit stream samples alike.

Each channel looks up its present level in a small registered gain table. The block multiplies the registered sample by that gain, then rounds and saturates the product back to 32 bits. A per-channel flag shows when the present level equals the target.

Top module: `dvol_softmute`

## Requirements
- R1: The gain for code c is 0 when c is 0. For any other c, take s = 255 - c, q = s / 12 and r = s % 12. The gain is M[r] >> q, where M = {65536, 61870, 58409, 55142, 52057, 49145, 46396, 43800, 41350, 39037, 36854, 34792} and 65536 is unity. Code 255 is 0 dB.
- R2: A channel's output is floor((x*g + 32768) / 65536), where x is the signed sample and g is the gain. The result is saturated to the signed 32-bit range. At unity gain the output equals the input for every value, including both extremes.
- R3: A sample accepted with in_valid at one clock edge appears on out_data, with out_valid high, after the second following edge. Channel k uses bits [32k +: 32] of in_data and out_data. out_data holds its value while out_valid is low.
- R4: Channel k takes its code from atten bits [8k +: 8]. Its level, gain and flag do not depend on any other channel's code.
- R5: The present level moves toward its target by exactly one code on every N-th accepted sample, where N = 2^rate_sel. The step counter restarts whenever the level equals the target. The level never moves in a cycle without in_valid.
- R6: If the target changes while a ramp is under way, the ramp continues from the present level toward the new target.
- R7: While mute is high, every channel's target is code 0, so its output ramps down to exactly zero. When mute is released, the targets return to the atten codes and the levels ramp back up.
- R8: settled[k] is 1 after an edge exactly when channel k's level after that edge equals the target seen at that edge.
- R9: While rst is high, the levels reset to code 0 and out_valid, out_data and settled are all reset to 0. After reset the outputs therefore fade in from silence.
- R10: Each sample is scaled with the level its channel had before the step taken at that same sample's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe for all channels |
| in_data | input | NCH*32 | Signed samples, channel k at [32k +: 32] |
| atten | input | NCH*8 | Level codes, channel k at [8k +: 8] |
| mute | input | 1 | Soft-mute request for all channels |
| rate_sel | input | 2 | Ramp pace, one code per 2^rate_sel samples |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | NCH*32 | Scaled samples |
| settled | output | NCH | Level equals target, per channel |

## Verification
The bench goes after ramp timing at slow rates. A step counter that is off by one would settle one or more samples early or late. Redirecting a ramp mid-flight catches a design that restarts from the old target or skips codes.

Rounding of odd samples at half gain is checked in both signs: truncation would give 1 instead of 2 for +3, and -2 instead of -1 for -3. Full-scale samples at unity gain expose a product that is rounded or saturated wrongly.

Mute with channels at different levels shows whether the codes truly bottom out at zero output. Release checks that the levels climb back to the programmed codes and do not jump straight to them.

// File: rtl/dvol_pkg.sv
package dvol_pkg;

  localparam int CODE_W    = 8;
  localparam int CODE_MAX  = (1 << CODE_W) - 1;
  localparam int GAIN_FRAC = 16;
  localparam int GAIN_W    = GAIN_FRAC + 1;
  localparam int UNITY     = 1 << GAIN_FRAC;
  localparam int OCT_STEPS = 12;

  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_UP   = 2'd1,
    RAMP_DOWN = 2'd2
  } ramp_dir_e;

  // Gain within one 6 dB band, 0.5 dB per entry, unsigned Q1.16.
  function automatic logic [GAIN_W-1:0] band_mant(input int unsigned r);
    case (r)
      0:  return GAIN_W'(65536);
      1:  return GAIN_W'(61870);
      2:  return GAIN_W'(58409);
      3:  return GAIN_W'(55142);
      4:  return GAIN_W'(52057);
      5:  return GAIN_W'(49145);
      6:  return GAIN_W'(46396);
      7:  return GAIN_W'(43800);
      8:  return GAIN_W'(41350);
      9:  return GAIN_W'(39037);
      10: return GAIN_W'(36854);
      default: return GAIN_W'(34792);
    endcase
  endfunction

  function automatic logic [GAIN_W-1:0] code_to_gain(input logic [CODE_W-1:0] c);
    int unsigned s;
    if (c == '0) return '0;
    s = CODE_MAX - int'(c);
    return band_mant(s % OCT_STEPS) >> (s / OCT_STEPS);
  endfunction

endpackage

// File: rtl/dvol_gain_rom.sv
module dvol_gain_rom
  import dvol_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [CODE_W-1:0]   addr,
  output logic [GAIN_W-1:0]   gain_q
);

  // Registered read, no reset on the data path, so it maps onto a ROM block.
  always_ff @(posedge clk) begin
    gain_q <= code_to_gain(addr);
  end

  p_gain_le_unity_r1: assert property (@(posedge clk) disable iff (rst)
    gain_q <= GAIN_W'(UNITY));

  p_code0_silent_r1: assert property (@(posedge clk) disable iff (rst)
    (addr == '0) |=> (gain_q == '0));

endmodule

// File: rtl/dvol_ramp.sv
module dvol_ramp
  import dvol_pkg::*;
#(
  parameter int RATE_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [CODE_W-1:0]   code,
  input  logic                mute,
  input  logic [RATE_W-1:0]   rate,
  output logic [CODE_W-1:0]   level_q,
  output logic                at_target_q
);

  localparam int CNT_W = (1 << RATE_W) - 1;

  logic [CODE_W-1:0] tgt, level_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, lim;
  ramp_dir_e         dir;

  always_comb begin
    tgt = mute ? '0 : code;
    if (level_q < tgt)      dir = RAMP_UP;
    else if (level_q > tgt) dir = RAMP_DOWN;
    else                    dir = RAMP_HOLD;
    lim     = CNT_W'((1 << rate) - 1);
    level_d = level_q;
    cnt_d   = cnt_q;
    if (dir == RAMP_HOLD) begin
      cnt_d = '0;
    end else if (smp_valid) begin
      if (cnt_q >= lim) begin
        cnt_d   = '0;
        level_d = (dir == RAMP_UP) ? level_q + 1'b1 : level_q - 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q     <= '0;
      cnt_q       <= '0;
      at_target_q <= 1'b0;
    end else begin
      level_q     <= level_d;
      cnt_q       <= cnt_d;
      at_target_q <= (level_d == tgt);
    end
  end

  p_single_step_r5: assert property (@(posedge clk) disable iff (rst)
    (level_q == $past(level_q)) || (level_q == $past(level_q) + 1'b1) ||
    (level_q == $past(level_q) - 1'b1));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(level_q));

  p_rise_toward_r6: assert property (@(posedge clk) disable iff (rst)
    (tgt > level_q) |=> (level_q >= $past(level_q)));

  p_fall_toward_r6: assert property (@(posedge clk) disable iff (rst)
    (tgt < level_q) |=> (level_q <= $past(level_q)));

  p_flag_match_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (at_target_q == (level_q == $past(tgt))));

endmodule

// File: rtl/dvol_scale.sv
module dvol_scale
  import dvol_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [DW-1:0]        smp,
  input  logic [GAIN_W-1:0]    gain,
  output logic [DW-1:0]        y_q
);

  localparam int PW = DW + GAIN_W + 1;
  localparam int SW = PW - GAIN_FRAC;

  logic signed [PW-1:0] prod, rnd;
  logic signed [SW-1:0] shifted;
  logic [DW-1:0]        sat;

  always_comb begin
    prod    = $signed(smp) * $signed({1'b0, gain});
    rnd     = prod + PW'(1 << (GAIN_FRAC - 1));
    shifted = rnd[PW-1:GAIN_FRAC];
    if (shifted[SW-1:DW-1] != {(SW-DW+1){shifted[SW-1]}})
      sat = shifted[SW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    else
      sat = shifted[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     y_q <= '0;
    else if (en) y_q <= sat;
  end

  function automatic logic [DW:0] mag(input logic [DW-1:0] v);
    return v[DW-1] ? ({1'b0, ~v} + 1'b1) : {1'b0, v};
  endfunction

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    en |=> (mag(y_q) <= mag($past(smp))));

  p_unity_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (en && gain == GAIN_W'(UNITY)) |=> (y_q == $past(smp)));

  p_zero_gain_r7: assert property (@(posedge clk) disable iff (rst)
    (en && gain == '0) |=> (y_q == '0));

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(y_q));

endmodule

// File: rtl/dvol_softmute.sv
module dvol_softmute
  import dvol_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int DW     = 32,
  parameter int RATE_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [NCH*DW-1:0]     in_data,
  input  logic [NCH*CODE_W-1:0] atten,
  input  logic                  mute,
  input  logic [RATE_W-1:0]     rate_sel,
  output logic                  out_valid,
  output logic [NCH*DW-1:0]     out_data,
  output logic [NCH-1:0]        settled
);

  logic s1_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      s1_valid  <= in_valid;
      out_valid <= s1_valid;
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [CODE_W-1:0] level;
    logic [GAIN_W-1:0] gain;
    logic [DW-1:0]     s1_smp;

    dvol_ramp #(.RATE_W(RATE_W)) u_ramp (
      .clk         (clk),
      .rst         (rst),
      .smp_valid   (in_valid),
      .code        (atten[k*CODE_W +: CODE_W]),
      .mute        (mute),
      .rate        (rate_sel),
      .level_q     (level),
      .at_target_q (settled[k])
    );

    dvol_gain_rom u_rom (
      .clk    (clk),
      .rst    (rst),
      .addr   (level),
      .gain_q (gain)
    );

    always_ff @(posedge clk) begin
      if (rst)           s1_smp <= '0;
      else if (in_valid) s1_smp <= in_data[k*DW +: DW];
    end

    dvol_scale #(.DW(DW)) u_scale (
      .clk  (clk),
      .rst  (rst),
      .en   (s1_valid),
      .smp  (s1_smp),
      .gain (gain),
      .y_q  (out_data[k*DW +: DW])
    );
  end

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);

  p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid);

endmodule

// File: tb/sim_dvol_softmute.sv
`timescale 1ns/1ps
module sim_dvol_softmute;

  localparam int NCH = 2;
  localparam int DW  = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [NCH*DW-1:0] in_data = '0;
  logic [NCH*8-1:0]  atten = '0;
  logic              mute = 1'b0;
  logic [1:0]        rate_sel = 2'd0;
  logic              out_valid;
  logic [NCH*DW-1:0] out_data;
  logic [NCH-1:0]    settled;

  always #4 clk = ~clk;

  dvol_softmute #(.NCH(NCH), .DW(DW), .RATE_W(2)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .atten(atten), .mute(mute), .rate_sel(rate_sel),
    .out_valid(out_valid), .out_data(out_data), .settled(settled)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference gain and scaling, taken from R1 and R2.
  int mtab [12] = '{65536, 61870, 58409, 55142, 52057, 49145,
                    46396, 43800, 41350, 39037, 36854, 34792};

  function automatic longint ref_gain(input int c);
    int s;
    if (c == 0) return 0;
    s = 255 - c;
    return longint'(mtab[s % 12] >> (s / 12));
  endfunction

  function automatic longint ref_scale(input longint x, input longint g);
    longint p;
    p = (x * g + 32768) >>> 16;
    if (p > 64'sd2147483647)  p = 64'sd2147483647;
    if (p < -64'sd2147483648) p = -64'sd2147483648;
    return p;
  endfunction

  function automatic longint lane(input logic [NCH*DW-1:0] v, input int k);
    return longint'($signed(v[k*DW +: DW]));
  endfunction

  // Behavioural model, updated once per clock edge.
  int     m_lvl [NCH];
  int     m_cnt [NCH];
  bit     m_st  [NCH];
  bit     e_v1, e_v;
  longint e_d1 [NCH];
  longint e_d  [NCH];

  always @(posedge clk) begin
    if (rst) begin
      e_v1 = 0; e_v = 0;
      for (int k = 0; k < NCH; k++) begin
        m_lvl[k] = 0; m_cnt[k] = 0; m_st[k] = 0; e_d1[k] = 0; e_d[k] = 0;
      end
    end else begin
      e_v = e_v1;
      if (e_v1) for (int k = 0; k < NCH; k++) e_d[k] = e_d1[k];
      e_v1 = in_valid;
      for (int k = 0; k < NCH; k++) begin
        int tgt;
        if (in_valid) e_d1[k] = ref_scale(lane(in_data, k), ref_gain(m_lvl[k])); // R10
        tgt = mute ? 0 : int'(atten[k*8 +: 8]);
        if (m_lvl[k] == tgt) m_cnt[k] = 0;
        else if (in_valid) begin
          if (m_cnt[k] >= (1 << rate_sel) - 1) begin
            m_lvl[k] = m_lvl[k] + ((tgt > m_lvl[k]) ? 1 : -1);
            m_cnt[k] = 0;
          end else m_cnt[k] = m_cnt[k] + 1;
        end
        m_st[k] = (m_lvl[k] == tgt);
      end
    end
  end

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 out_valid", longint'(out_valid), longint'(e_v));
      for (int k = 0; k < NCH; k++) begin
        chk("R8 settled", longint'(settled[k]), longint'(m_st[k]));
        if (out_valid) chk("R2 out_data", lane(out_data, k), e_d[k]);
      end
    end
  end

  task automatic stream(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = {$urandom(), $urandom()};
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, input logic [31:0] b,
                       output longint oa, output longint ob);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = {b, a};
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    oa = lane(out_data, 0);
    ob = lane(out_data, 1);
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    longint a, b;
    // R9 reset state
    repeat (4) @(negedge clk);
    chk("R9 out_valid", longint'(out_valid), 0);
    chk("R9 out_data", longint'(out_data != '0), 0);
    chk("R9 settled", longint'(settled), 0);
    rst = 1'b0;

    // Fade in from silence to 0 dB, then unity pass (R2, R9)
    atten = {8'd255, 8'd255};
    stream(254);
    chk("R9 fade-in not done", longint'(settled), 0);
    stream(1);
    chk("R8 both settled", longint'(settled), 3);
    probe(32'h7FFF_FFFF, 32'h8000_0000, a, b);
    chk("R2 unity max", a, 64'sd2147483647);
    chk("R2 unity min", b, -64'sd2147483648);

    // Half gain on ch0 only (R4), rounding in both signs (R2)
    atten = {8'd255, 8'd243};
    stream(20);
    probe(32'd3, 32'd5, a, b);
    chk("R2 round +3", a, 2);
    chk("R4 ch1 untouched", b, 5);
    probe(-32'sd3, -32'sd5, a, b);
    chk("R2 round -3", a, -1);
    chk("R4 ch1 untouched neg", b, -5);

    // Slow rate: 10 steps at N=4 take 40 samples (R5)
    rate_sel = 2'd2;
    atten = {8'd255, 8'd233};
    stream(39);
    chk("R5 one sample short", longint'(settled[0]), 0);
    repeat (3) @(negedge clk);
    chk("R5 idle no move", longint'(settled[0]), 0);
    stream(1);
    chk("R5 reached at 40", longint'(settled[0]), 1);

    // Redirect mid-ramp (R6)
    rate_sel = 2'd0;
    atten = {8'd255, 8'd255};
    stream(5);
    atten = {8'd255, 8'd230};
    stream(7);
    chk("R6 redirect early", longint'(settled[0]), 0);
    stream(1);
    chk("R6 redirect reached", longint'(settled[0]), 1);

    // Soft mute down and release (R7)
    mute = 1'b1;
    stream(255);
    chk("R7 muted settled", longint'(settled), 3);
    probe(32'h7FFF_FFFF, 32'h8000_0000, a, b);
    chk("R7 ch0 silent", a, 0);
    chk("R7 ch1 silent", b, 0);
    mute = 1'b0;
    stream(100);
    chk("R7 release still ramping", longint'(settled[1]), 0);
    stream(160);
    chk("R7 release settled", longint'(settled), 3);

    // Code 0 silence and a 24 dB code (R1)
    atten = {8'd207, 8'd0};
    stream(260);
    probe(32'h7FFF_FFFF, 32'h7FFF_FFFF, a, b);
    chk("R1 code 0 silent", a, 0);
    chk("R1 code 207", b, 134217728);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule